// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution unit handles the eight bit-field instructions of a 64-bit RISC integer pipeline. Four of them pull a contiguous field out of the source operand and right-align it. The other four splice the low bits of the source operand into a window of the target operand. All eight share one pair of 5-bit position fields. Each variant reinterprets those fields: it may add 32 to the low position, to the length, or to the top position. The two narrow variants work on a 32-bit value and sign-extend the result to 64 bits.

The unit takes the raw 32-bit instruction word and the two 64-bit register operands (`rs_i` is the source, `rt_i` is the target). From these it produces the result, the destination register index and a flag for an encoding the unit cannot execute. A parameter selects whether the outputs come straight from the logic or pass through one register stage.

Top module: `bitfield_unit`

## Requirements
- R1: The unit decodes only when instruction bits 31:26 equal 0x1F. With any other major opcode, `illegal_o` is 1 and both `result_o` and `dest_o` are zero.
- R2: The function code is in bits 5:0. Codes 0x00 to 0x07 are executed. Any higher code sets `illegal_o` and forces `result_o` and `dest_o` to zero.
- R3: For a legal encoding, `dest_o` equals instruction bits 20:16, which name the target register. It is never taken from bits 15:11.
- R4: Narrow extract (function 0x00): the low position is bits 10:6 and the length is bits 15:11 plus one. The result is `rs_i` shifted right by the low position, masked to the length, then sign-extended from bit 31 to bit 63.
- R5: Wide extract (function 0x03) uses the same fields as R4 but zero-fills every bit above the length and applies no sign extension.
- R6: Wide extract with long length (function 0x01) adds 32 to the length. A length of 64 yields all of `rs_i` shifted right, with no lost or wrapped bits.
- R7: Wide extract from the upper half (function 0x02) adds 32 to the low position. The length is bits 15:11 plus one and the result is zero-filled.
- R8: Narrow insert (function 0x04): bits 10:6 give the low position and bits 15:11 give the top position. Bits top..low of `rt_i` are replaced by the low bits of `rs_i`. The other bits of `rt_i` are kept, and the result is sign-extended from bit 31.
- R9: Wide inserts keep every `rt_i` bit outside the window and return all 64 bits. Function 0x07 uses the fields as given. Function 0x05 adds 32 to the top position. Function 0x06 adds 32 to both the low and the top position.
- R10: An insert whose top position, after its offset, is below its low position sets `illegal_o`. In that case `result_o` and `dest_o` are zero.
- R11: With `REG_OUT`=1 every output appears one clock after its inputs, and an active-low reset clears all outputs to zero. With `REG_OUT`=0 the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rst_n | input | 1 | Active-low reset, clears the output stage |
| insn_i | input | 32 | Instruction word |
| rs_i | input | 64 | Source operand value |
| rt_i | input | 64 | Target operand value, the base for inserts |
| result_o | output | 64 | Extracted or merged value |
| dest_o | output | 5 | Index of the register to write |
| illegal_o | output | 1 | Encoding the unit cannot execute |

## Verification
The bench builds two copies of the unit with the default 64-bit operand width: one with `REG_OUT`=1 and one with `REG_OUT`=0. Both copies get the same stimulus. The registered copy is checked one clock after the combinational one, so R11's one-cycle delay and reset clearing are compared directly against same-cycle behaviour. At 64 bits the two 5-bit fields plus the +32 offsets reach every window edge: a length of 64, a low position of 63, and inserts that meet, cross or invert their bounds. Every function code is swept over all 1024 field pairs with random operands.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  // Major opcode that selects this unit, and instruction field positions.
  localparam logic [5:0] OPC_BITFIELD = 6'h1F;
  localparam int OPC_POS  = 26;
  localparam int FN_POS   = 0;
  localparam int LO_POS   = 6;
  localparam int HI_POS   = 11;
  localparam int DEST_POS = 16;
  localparam int SRC_POS  = 21;

  // Variant encoding equals the low three bits of the function code.
  typedef enum logic [2:0] {
    BF_XTR_N   = 3'd0,  // narrow extract
    BF_XTR_LEN = 3'd1,  // extract, length +32
    BF_XTR_UP  = 3'd2,  // extract, low position +32
    BF_XTR_W   = 3'd3,  // wide extract
    BF_INS_N   = 3'd4,  // narrow insert
    BF_INS_TOP = 3'd5,  // insert, top +32
    BF_INS_UP  = 3'd6,  // insert, low and top +32
    BF_INS_W   = 3'd7   // wide insert
  } bf_kind_e;

  function automatic logic kind_is_insert(bf_kind_e k);
    return k[2];
  endfunction

  function automatic logic kind_is_narrow(bf_kind_e k);
    return (k == BF_XTR_N) || (k == BF_INS_N);
  endfunction

  function automatic logic kind_lo_offset(bf_kind_e k);
    return (k == BF_XTR_UP) || (k == BF_INS_UP);
  endfunction

  function automatic logic kind_hi_offset(bf_kind_e k);
    return (k == BF_XTR_LEN) || (k == BF_INS_TOP) || (k == BF_INS_UP);
  endfunction

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IW     = 32,
  parameter int RIDX_W = 5
) (
  input  logic [IW-1:0]          insn,
  output bf_kind_e               kind,
  output logic [$clog2(XLEN)-1:0] lo_pos,
  output logic [$clog2(XLEN)-1:0] hi_pos,
  output logic [$clog2(XLEN):0]   field_len,
  output logic                    is_insert,
  output logic                    is_narrow,
  output logic                    opc_hit,
  output logic                    fn_known,
  output logic                    order_bad,
  output logic                    illegal,
  output logic [RIDX_W-1:0]       dest
);

  localparam int LW   = $clog2(XLEN);
  localparam int SW   = LW + 1;
  localparam int FW   = LW - 1;
  localparam int HALF = XLEN / 2;

  logic [5:0]    opc_f;
  logic [5:0]    fn_f;
  logic [FW-1:0] lo_f;
  logic [FW-1:0] hi_f;
  logic          unused_src_field;

  assign opc_f = insn[OPC_POS +: 6];
  assign fn_f  = insn[FN_POS +: 6];
  assign lo_f  = insn[LO_POS +: FW];
  assign hi_f  = insn[HI_POS +: FW];
  assign unused_src_field = ^insn[SRC_POS +: RIDX_W];

  // Position arithmetic kept in functions so each step is named.
  function automatic logic [LW-1:0] add_offset(logic [FW-1:0] f, logic off);
    return {1'b0, f} + (off ? LW'(HALF) : LW'(0));
  endfunction

  function automatic logic [SW-1:0] len_from_bounds(logic [LW-1:0] hi, logic [LW-1:0] lo);
    return {1'b0, hi} + SW'(1) - {1'b0, lo};
  endfunction

  function automatic logic [SW-1:0] len_from_field(logic [FW-1:0] f, logic off);
    return {2'b00, f} + SW'(1) + (off ? SW'(HALF) : SW'(0));
  endfunction

  assign opc_hit   = (opc_f == OPC_BITFIELD);
  assign fn_known  = (fn_f[5:3] == 3'b000);
  assign kind      = bf_kind_e'(fn_f[2:0]);
  assign is_insert = kind_is_insert(kind);
  assign is_narrow = kind_is_narrow(kind);

  always_comb begin
    lo_pos = add_offset(lo_f, kind_lo_offset(kind));
    hi_pos = '0;
    field_len = '0;
    if (is_insert) begin
      hi_pos    = add_offset(hi_f, kind_hi_offset(kind));
      field_len = len_from_bounds(hi_pos, lo_pos);
    end else begin
      field_len = len_from_field(hi_f, kind_hi_offset(kind));
    end
  end

  assign order_bad = is_insert && (hi_pos < lo_pos);
  assign illegal   = !opc_hit || !fn_known || order_bad;
  assign dest      = illegal ? '0 : insn[DEST_POS +: RIDX_W];

endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
  parameter int XLEN = 64
) (
  input  logic [$clog2(XLEN):0]   field_len,
  input  logic [$clog2(XLEN)-1:0] lo_pos,
  output logic [XLEN-1:0]         low_mask,
  output logic [XLEN-1:0]         win_mask
);

  localparam int SW = $clog2(XLEN) + 1;

  // One comparator per bit: a length equal to XLEN sets every bit and
  // never forms a shift by the full word width.
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    assign low_mask[b] = (SW'(b) < field_len);
  end

  assign win_mask = low_mask << lo_pos;

endmodule

// File: rtl/bfx_merge.sv
module bfx_merge #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         rs,
  input  logic [XLEN-1:0]         rt,
  input  logic [$clog2(XLEN)-1:0] lo_pos,
  input  logic [XLEN-1:0]         low_mask,
  input  logic [XLEN-1:0]         win_mask,
  input  logic                    is_insert,
  input  logic                    is_narrow,
  input  logic                    illegal,
  output logic [XLEN-1:0]         result
);

  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] pull_field(logic [XLEN-1:0] src,
                                                 logic [$clog2(XLEN)-1:0] lo,
                                                 logic [XLEN-1:0] m);
    return (src >> lo) & m;
  endfunction

  function automatic logic [XLEN-1:0] splice(logic [XLEN-1:0] src,
                                             logic [XLEN-1:0] base,
                                             logic [$clog2(XLEN)-1:0] lo,
                                             logic [XLEN-1:0] w);
    return (base & ~w) | ((src << lo) & w);
  endfunction

  function automatic logic [XLEN-1:0] widen(logic [XLEN-1:0] v);
    return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  logic [XLEN-1:0] raw;

  assign raw = is_insert ? splice(rs, rt, lo_pos, win_mask)
                         : pull_field(rs, lo_pos, low_mask);

  always_comb begin
    if (illegal)        result = '0;
    else if (is_narrow) result = widen(raw);
    else                result = raw;
  end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfx_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IW      = 32,
  parameter int RIDX_W  = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     insn_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   rt_i,
  output logic [XLEN-1:0]   result_o,
  output logic [RIDX_W-1:0] dest_o,
  output logic              illegal_o
);

  localparam int LW   = $clog2(XLEN);
  localparam int SW   = LW + 1;
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] LOW_HALF = {{HALF{1'b0}}, {HALF{1'b1}}};

  bf_kind_e          dec_kind;
  logic [LW-1:0]     dec_lo;
  logic [LW-1:0]     dec_hi;
  logic [SW-1:0]     dec_len;
  logic              dec_insert;
  logic              dec_narrow;
  logic              dec_opc_hit;
  logic              dec_fn_known;
  logic              dec_order_bad;
  logic              dec_illegal;
  logic [RIDX_W-1:0] dec_dest;
  logic [XLEN-1:0]   msk_low;
  logic [XLEN-1:0]   msk_win;
  logic [XLEN-1:0]   mrg_result;

  bfx_decode #(.XLEN(XLEN), .IW(IW), .RIDX_W(RIDX_W)) u_decode (
    .insn      (insn_i),
    .kind      (dec_kind),
    .lo_pos    (dec_lo),
    .hi_pos    (dec_hi),
    .field_len (dec_len),
    .is_insert (dec_insert),
    .is_narrow (dec_narrow),
    .opc_hit   (dec_opc_hit),
    .fn_known  (dec_fn_known),
    .order_bad (dec_order_bad),
    .illegal   (dec_illegal),
    .dest      (dec_dest)
  );

  bfx_mask #(.XLEN(XLEN)) u_mask (
    .field_len (dec_len),
    .lo_pos    (dec_lo),
    .low_mask  (msk_low),
    .win_mask  (msk_win)
  );

  bfx_merge #(.XLEN(XLEN)) u_merge (
    .rs        (rs_i),
    .rt        (rt_i),
    .lo_pos    (dec_lo),
    .low_mask  (msk_low),
    .win_mask  (msk_win),
    .is_insert (dec_insert),
    .is_narrow (dec_narrow),
    .illegal   (dec_illegal),
    .result    (mrg_result)
  );

  logic unused_kind;
  assign unused_kind = ^dec_kind;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result_o  <= '0;
        dest_o    <= '0;
        illegal_o <= 1'b0;
      end else begin
        result_o  <= mrg_result;
        dest_o    <= dec_dest;
        illegal_o <= dec_illegal;
      end
    end

    AST_STAGE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (result_o == $past(mrg_result)) && (illegal_o == $past(dec_illegal))); // R11
  end else begin : g_comb
    assign result_o  = mrg_result;
    assign dest_o    = dec_dest;
    assign illegal_o = dec_illegal;
  end

  AST_FOREIGN_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_opc_hit |-> (mrg_result == '0) && (dec_dest == '0)); // R1

  AST_UNKNOWN_FN: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_fn_known |-> (mrg_result == '0)); // R2

  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_illegal |-> ($countones(msk_low) == int'(dec_len))); // R6

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_illegal && !dec_insert && !dec_narrow) |-> ((mrg_result & ~msk_low) == '0)); // R5

  AST_NARROW_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_illegal && dec_narrow) |-> (mrg_result[XLEN-1:HALF] == {HALF{mrg_result[HALF-1]}})); // R4

  AST_INSERT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_illegal && dec_insert) |->
      ((((mrg_result ^ rt_i) & ~msk_win) & (dec_narrow ? LOW_HALF : '1)) == '0)); // R9

  AST_INSERT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_insert && (dec_hi < dec_lo)) |-> (dec_illegal && (mrg_result == '0))); // R10

endmodule

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] rs = '0;
  logic [63:0] rt = '0;
  logic [63:0] res_r, res_c;
  logic [4:0]  dst_r, dst_c;
  logic        ill_r, ill_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bitfield_unit #(.REG_OUT(1'b1)) u_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .insn_i(insn), .rs_i(rs), .rt_i(rt),
    .result_o(res_r), .dest_o(dst_r), .illegal_o(ill_r));

  bitfield_unit #(.REG_OUT(1'b0)) u_bitfield_unit_comb (
    .clk(clk), .rst_n(rst_n), .insn_i(insn), .rs_i(rs), .rt_i(rt),
    .result_o(res_c), .dest_o(dst_c), .illegal_o(ill_c));

  function automatic logic [31:0] enc(logic [5:0] opc, logic [4:0] d,
                                      logic [4:0] hi, logic [4:0] lo, logic [5:0] fn);
    return {opc, 5'd9, d, hi, lo, fn};
  endfunction

  // Bit-by-bit restatement of the requirements.
  function automatic void model(input logic [31:0] w, input logic [63:0] s, input logic [63:0] t,
                                output logic [63:0] r, output logic [4:0] d, output logic il);
    int lo, hi, len, fn;
    bit ins;
    r = '0; d = '0; il = 1'b0;
    fn = int'(w[5:0]);
    if (w[31:26] != 6'h1F || fn > 7) begin il = 1'b1; return; end
    ins = (fn >= 4);
    lo = int'(w[10:6]); hi = int'(w[15:11]); len = hi + 1;
    if (fn == 1) len = hi + 33;
    if (fn == 2) lo = lo + 32;
    if (fn == 5) hi = hi + 32;
    if (fn == 6) begin lo = lo + 32; hi = hi + 32; end
    if (ins && hi < lo) begin il = 1'b1; return; end
    if (!ins) begin
      for (int i = 0; i < len; i++) if (lo + i < 64) r[i] = s[lo + i];
    end else begin
      r = t;
      for (int i = lo; i <= hi; i++) r[i] = s[i - lo];
    end
    if (fn == 0 || fn == 4) r[63:32] = {32{r[31]}};
    d = w[20:16];
  endfunction

  function automatic string tag_for(logic [31:0] w, logic exp_il);
    int fn = int'(w[5:0]);
    if (w[31:26] != 6'h1F) return "R1";
    if (fn > 7) return "R2";
    if (exp_il) return "R10";
    case (fn)
      0: return "R4";
      3: return "R5";
      1: return "R6";
      2: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic cmp(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s insn=%h actual=%h expected=%h", req, what, insn, got, exp);
    end
  endtask

  // Drive one vector; check the same-cycle copy, then the staged copy.
  task automatic apply(logic [31:0] w, logic [63:0] s, logic [63:0] t);
    logic [63:0] er; logic [4:0] ed; logic ei; string tg;
    @(negedge clk);
    insn = w; rs = s; rt = t;
    model(w, s, t, er, ed, ei);
    tg = tag_for(w, ei);
    #1;
    cmp(tg, "result", res_c, er);
    cmp("R3", "dest", {59'd0, dst_c}, {59'd0, ed});
    cmp(tg, "illegal", {63'd0, ill_c}, {63'd0, ei});
    @(posedge clk); #1;
    cmp("R11", "staged result", res_r, er);
    cmp("R11", "staged dest", {59'd0, dst_r}, {59'd0, ed});
    cmp("R11", "staged illegal", {63'd0, ill_r}, {63'd0, ei});
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0b1f));
    insn = enc(6'h1F, 5'd3, 5'd31, 5'd0, 6'h03);
    rs = '1; rt = '1;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset holds the staged outputs at zero
    cmp("R11", "reset result", res_r, 64'd0);
    cmp("R11", "reset flags", {58'd0, dst_r, ill_r}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // Directed corners
    apply(enc(6'h1F, 5'd4, 5'd31, 5'd0, 6'h01), 64'hDEAD_BEEF_0123_4567, 64'h0);  // R6 length 64
    apply(enc(6'h1F, 5'd4, 5'd0, 5'd31, 6'h02), 64'h8000_0000_0000_0000, 64'h0);  // R7 low 63
    apply(enc(6'h1F, 5'd7, 5'd31, 5'd0, 6'h00), 64'h0000_0000_8000_0000, 64'h0);  // R4 sign
    apply(enc(6'h1F, 5'd7, 5'd3, 5'd8, 6'h04), 64'hFFFF, 64'h1234);               // R10
    apply(enc(6'h1F, 5'd7, 5'd30, 5'd31, 6'h06), 64'hFFFF, 64'h1234);             // R10 upper
    apply(enc(6'h1F, 5'd7, 5'd31, 5'd31, 6'h05), 64'h0, 64'hFFFF_FFFF_FFFF_FFFF); // R9 full top
    apply(enc(6'h1F, 5'd7, 5'd0, 5'd0, 6'h05), 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);   // R9 len 33
    apply(enc(6'h1F, 5'd2, 5'd31, 5'd0, 6'h04), 64'h8000_0000, 64'h0);            // R8 sign
    apply(enc(6'h1C, 5'd2, 5'd31, 5'd0, 6'h03), 64'hFFFF, 64'h0);                 // R1
    apply(enc(6'h1F, 5'd2, 5'd31, 5'd0, 6'h08), 64'hFFFF, 64'h0);                 // R2
    apply(enc(6'h1F, 5'd2, 5'd31, 5'd0, 6'h24), 64'hFFFF, 64'h0);                 // R2

    // Every function code over every field pair
    for (int fn = 0; fn < 8; fn++)
      for (int hi = 0; hi < 32; hi++)
        for (int lo = 0; lo < 32; lo++)
          apply(enc(6'h1F, 5'($urandom()), 5'(hi), 5'(lo), 6'(fn)), rnd64(), rnd64());

    // Fully random encodings, biased toward the unit's opcode
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] w = $urandom();
      if ($urandom_range(3) != 0) w[31:26] = 6'h1F;
      if ($urandom_range(3) != 0) w[5:3] = 3'b000;
      apply(w, rnd64(), rnd64());
    end

    finish_run();
  end

endmodule